// File: doc/BRIEF.md
# Serial Management Slave with Register Bank

This block is the management end of a PHY-side control port. It is clocked only by the management clock, which may stop between frames. It watches the bidirectional data line, separated at the pad into an input, an output and an output enable. It finds frames that begin with a run of ones followed by a start pattern. It checks the opcode and the device address, then reads or writes one 16-bit entry of a 32-entry register bank. On a read it takes the line in the second turnaround bit and shifts the selected register out, most significant bit first.

The device address and a few register defaults come from strap inputs. These are captured while reset is held, so later changes on those pins have no effect. The bank has fully writable entries, partly writable entries, read-only entries and reserved addresses. Two control bits clear themselves. A write with the software-reset bit set reloads every entry from its default. Two lock inputs hold the advertisement entries steady while the link side is busy sending its pulses.

Top module: `mdioMgmtSlave`

## Requirements
- R1: A frame is accepted only after at least PRE_LEN (32) consecutive ones followed by the start bits 0 then 1. A shorter run of ones followed by the same frame has no effect.
- R2: The 5-bit device address is captured from strapPhyAddr while rstN is low. Frames carrying any other address neither drive the line nor change a register, including after the strap pins change.
- R3: Bit positions count from the bit after the start pattern. Bits 0-1 are the opcode, bits 2-6 the device address (MSB first), bits 7-11 the register address (MSB first), bits 12-13 the turnaround and bits 14-29 the data (MSB first). On a matching read (opcode 10), mdioOe is low during bit 12. mdioOe is high with mdioOut low during bit 13. Bits 14-29 carry the register's bits 15..0, and mdioOe is low again from bit 30.
- R4: On a matching write (opcode 01), the data is committed at the edge that samples bit 29. Only writable bits change. Entries 1, 2, 3, 5, 6, 8, 10, 15 and 17 are read-only. Entry 7 keeps bits 11 and 14 at 0. Entries 0, 4, 9, 16 and 20 are fully writable.
- R5: Reset values are as follows. Entry 0 is 0x1140, entry 1 is 0x7969, entries 2 and 3 are ID_HI and ID_LO, and entry 4 is 0x05E1. Entry 6 is 0x0004, entry 7 is 0x2001, entry 9 is 0x0300, entry 15 is 0x3000 and entry 20 is 0x0804. Entry 16 has bit 11 set, bit 15 clear, bit 14 from strapLedMode, bit 1 from strapTxClkDelay and bit 0 from strapRxClkDelay.
- R6: A write to entry 0 with bit 15 set restores every entry to its R5 value, using the captured straps for entry 16. Bits 15 and 9 of entry 0 always read 0.
- R7: While advLock is high, writes to entries 4 and 9 leave them unchanged. While npLock is high, writes to entry 7 leave it unchanged. Other entries stay writable.
- R8: Addresses 11-14, 18, 19 and 21-31 read as 0 and ignore writes.
- R9: Frames with opcode 00 or 11 never drive the line and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock, may be non-continuous |
| rstN | input | 1 | Asynchronous active-low reset; straps are captured while low |
| mdioIn | input | 1 | Data line as seen at the pad |
| mdioOut | output | 1 | Value driven onto the data line |
| mdioOe | output | 1 | Output enable for the data line pad |
| strapPhyAddr | input | 5 | Device address strap |
| strapRxClkDelay | input | 1 | Default for entry 16 bit 0 |
| strapTxClkDelay | input | 1 | Default for entry 16 bit 1 |
| strapLedMode | input | 1 | Default for entry 16 bit 14 |
| advLock | input | 1 | Holds entries 4 and 9 against writes |
| npLock | input | 1 | Holds entry 7 against writes |

## Verification
The bench builds the block with PRE_LEN at 32 and the default identifier values. This makes both the exact preamble threshold (31 versus 32 ones) and the fixed identifier read-back reachable. Straps are set to a non-trivial address and mixed strap bits, then flipped after reset. This shows that capture happens during reset and that software reset reuses the captured copy rather than the live pins. Random frames mix matching reads, writes, foreign-address reads and software resets against a bench model. Directed frames cover locks, reserved addresses, illegal opcodes and the turnaround timing.

// File: rtl/mdioMgmtPkg.sv
package mdioMgmtPkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;
  localparam int PHY_W   = 5;
  localparam int REG_CNT = 1 << ADDR_W;

  typedef struct packed {
    logic ledSel;
    logic txDly;
    logic rxDly;
  } strapT;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } wrStrobeT;

  function automatic logic isReserved(input logic [ADDR_W-1:0] a);
    return (a >= 5'd11 && a <= 5'd14) || a == 5'd18 || a == 5'd19 || a >= 5'd21;
  endfunction

  function automatic logic [REG_W-1:0] writeMask(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0, 5'd4, 5'd9, 5'd16, 5'd20: return 16'hFFFF;
      5'd7:                           return 16'hB7FF;
      default:                        return 16'h0000;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] selfClearMask(input logic [ADDR_W-1:0] a);
    return (a == 5'd0) ? 16'h8200 : 16'h0000;
  endfunction

  function automatic logic isAdvReg(input logic [ADDR_W-1:0] a);
    return a == 5'd4 || a == 5'd9;
  endfunction

  function automatic logic isNextPageReg(input logic [ADDR_W-1:0] a);
    return a == 5'd7;
  endfunction

  function automatic logic [REG_W-1:0] resetValue(input logic [ADDR_W-1:0] a,
                                                   input strapT s,
                                                   input logic [REG_W-1:0] idHi,
                                                   input logic [REG_W-1:0] idLo);
    case (a)
      5'd0:    return 16'h1140;
      5'd1:    return 16'h7969;
      5'd2:    return idHi;
      5'd3:    return idLo;
      5'd4:    return 16'h05E1;
      5'd6:    return 16'h0004;
      5'd7:    return 16'h2001;
      5'd9:    return 16'h0300;
      5'd15:   return 16'h3000;
      5'd16:   return {1'b0, s.ledSel, 12'h200, s.txDly, s.rxDly};
      5'd20:   return 16'h0804;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/mdioFrameCtl.sv
module mdioFrameCtl
  import mdioMgmtPkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  input  logic [PHY_W-1:0]  strapAddr,
  input  logic [REG_W-1:0]  rdData,
  output wrStrobeT          wr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam int CNT_W    = $clog2(PRE_LEN + 1);
  localparam int HDR_BITS = 2 + PHY_W + ADDR_W;
  localparam int TA_LAST  = HDR_BITS + 1;
  localparam int LAST_BIT = HDR_BITS + 2 + REG_W - 1;
  localparam int BIT_W    = $clog2(LAST_BIT + 1);
  localparam int IDX_W    = $clog2(REG_W);

  typedef enum logic [1:0] {S_IDLE, S_START, S_FRAME} stateT;

  stateT               state;
  logic [CNT_W-1:0]    preCnt;
  logic [BIT_W-1:0]    bitCnt;
  logic [HDR_BITS-2:0] hdrQ;
  logic [REG_W-2:0]    dataQ;
  logic [PHY_W-1:0]    phyQ;
  logic [ADDR_W-1:0]   regAddrQ;
  logic                isRdQ;
  logic                isWrQ;

  logic [HDR_BITS-1:0] hdrNow;
  logic [1:0]          opNow;
  logic                phyHit;
  logic [IDX_W-1:0]    rdIdx;
  logic                lastBit;

  assign hdrNow  = {hdrQ, mdioIn};
  assign opNow   = hdrNow[HDR_BITS-1 -: 2];
  assign phyHit  = hdrNow[ADDR_W +: PHY_W] == phyQ;
  assign rdIdx   = IDX_W'(BIT_W'(LAST_BIT - 1) - bitCnt);
  assign lastBit = bitCnt == BIT_W'(LAST_BIT);

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      preCnt   <= '0;
      bitCnt   <= '0;
      hdrQ     <= '0;
      dataQ    <= '0;
      phyQ     <= strapAddr;
      regAddrQ <= '0;
      isRdQ    <= 1'b0;
      isWrQ    <= 1'b0;
      mdioOut  <= 1'b0;
      mdioOe   <= 1'b0;
    end else begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
      case (state)
        S_IDLE: begin
          if (mdioIn) begin
            if (preCnt != CNT_W'(PRE_LEN)) preCnt <= preCnt + 1'b1;
          end else begin
            if (preCnt == CNT_W'(PRE_LEN)) state <= S_START;
            preCnt <= '0;
          end
        end
        S_START: begin
          bitCnt <= '0;
          isRdQ  <= 1'b0;
          isWrQ  <= 1'b0;
          state  <= mdioIn ? S_FRAME : S_IDLE;
        end
        default: begin
          if (bitCnt < BIT_W'(HDR_BITS - 1)) hdrQ <= hdrNow[HDR_BITS-2:0];
          if (bitCnt == BIT_W'(HDR_BITS - 1)) begin
            isRdQ    <= phyHit && opNow == 2'b10;
            isWrQ    <= phyHit && opNow == 2'b01;
            regAddrQ <= hdrNow[ADDR_W-1:0];
          end
          if (bitCnt > BIT_W'(TA_LAST)) dataQ <= {dataQ[REG_W-3:0], mdioIn};
          if (isRdQ && bitCnt >= BIT_W'(HDR_BITS) && bitCnt < BIT_W'(LAST_BIT)) begin
            mdioOe  <= 1'b1;
            mdioOut <= (bitCnt == BIT_W'(HDR_BITS)) ? 1'b0 : rdData[rdIdx];
          end
          if (lastBit) begin
            state  <= S_IDLE;
            bitCnt <= '0;
            preCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign wr.we   = state == S_FRAME && lastBit && isWrQ;
  assign wr.addr = regAddrQ;
  assign wr.data = {dataQ, mdioIn};
  assign rdAddr  = regAddrQ;

  a_r3_ta_drives_low: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);
  a_r1_quiet_outside_frame: assert property (@(posedge mdc) disable iff (!rstN)
    state != S_FRAME |-> !mdioOe);
  a_r4_single_commit: assert property (@(posedge mdc) disable iff (!rstN)
    wr.we |=> !wr.we);
  a_r9_no_drive_on_write: assert property (@(posedge mdc) disable iff (!rstN)
    isWrQ |-> !mdioOe);
endmodule

// File: rtl/mdioRegBank.sv
module mdioRegBank
  import mdioMgmtPkg::*;
#(
  parameter logic [REG_W-1:0] ID_HI = 16'h1C2A,
  parameter logic [REG_W-1:0] ID_LO = 16'h5B31
) (
  input  logic              mdc,
  input  logic              rstN,
  input  strapT             strapPins,
  input  wrStrobeT          wr,
  input  logic              advLock,
  input  logic              npLock,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData
);
  strapT            strapQ;
  logic [REG_W-1:0] regRd [REG_CNT];
  logic             swReset;
  logic             lockHit;

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) strapQ <= strapPins;
    else       strapQ <= strapQ;
  end

  assign swReset = wr.we && wr.addr == '0 && wr.data[REG_W-1];
  assign lockHit = (isAdvReg(wr.addr) && advLock) || (isNextPageReg(wr.addr) && npLock);

  for (genvar i = 0; i < REG_CNT; i++) begin : gReg
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    if (isReserved(IDX)) begin : gRsv
      assign regRd[i] = '0;
    end else begin : gImp
      localparam logic [REG_W-1:0] MASK = writeMask(IDX);
      localparam logic [REG_W-1:0] SC   = selfClearMask(IDX);
      logic [REG_W-1:0] q;
      always_ff @(posedge mdc or negedge rstN) begin
        if (!rstN)
          q <= resetValue(IDX, strapPins, ID_HI, ID_LO);
        else if (swReset)
          q <= resetValue(IDX, strapQ, ID_HI, ID_LO);
        else if (wr.we && wr.addr == IDX && !lockHit)
          q <= (q & ~MASK) | (wr.data & MASK & ~SC);
      end
      assign regRd[i] = q;
    end
  end

  assign rdData = regRd[rdAddr];

  a_r6_swreset_restores: assert property (@(posedge mdc) disable iff (!rstN)
    swReset |=> regRd[4] == 16'h05E1 && regRd[7] == 16'h2001);
  a_r6_selfclear_bits: assert property (@(posedge mdc) disable iff (!rstN)
    wr.we && wr.addr == 5'd0 |=> !regRd[0][15] && !regRd[0][9]);
  a_r7_adv_locked: assert property (@(posedge mdc) disable iff (!rstN)
    wr.we && isAdvReg(wr.addr) && advLock |=> $stable(regRd[4]) && $stable(regRd[9]));
  a_r7_np_locked: assert property (@(posedge mdc) disable iff (!rstN)
    wr.we && isNextPageReg(wr.addr) && npLock |=> $stable(regRd[7]));
  a_r4_readonly_held: assert property (@(posedge mdc) disable iff (!rstN)
    wr.we && wr.addr == 5'd1 |=> $stable(regRd[1]));
endmodule

// File: rtl/mdioMgmtSlave.sv
module mdioMgmtSlave
  import mdioMgmtPkg::*;
#(
  parameter int               PRE_LEN = 32,
  parameter logic [REG_W-1:0] ID_HI   = 16'h1C2A,
  parameter logic [REG_W-1:0] ID_LO   = 16'h5B31
) (
  input  logic       mdc,
  input  logic       rstN,
  input  logic       mdioIn,
  output logic       mdioOut,
  output logic       mdioOe,
  input  logic [4:0] strapPhyAddr,
  input  logic       strapRxClkDelay,
  input  logic       strapTxClkDelay,
  input  logic       strapLedMode,
  input  logic       advLock,
  input  logic       npLock
);
  strapT             strapPins;
  wrStrobeT          wr;
  logic [ADDR_W-1:0] rdAddr;
  logic [REG_W-1:0]  rdData;

  assign strapPins.rxDly  = strapRxClkDelay;
  assign strapPins.txDly  = strapTxClkDelay;
  assign strapPins.ledSel = strapLedMode;

  mdioFrameCtl #(.PRE_LEN(PRE_LEN)) u_ctl (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .strapAddr(strapPhyAddr),
    .rdData(rdData), .wr(wr), .rdAddr(rdAddr), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  mdioRegBank #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_bank (
    .mdc(mdc), .rstN(rstN), .strapPins(strapPins), .wr(wr), .advLock(advLock),
    .npLock(npLock), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/mdioMgmtSlave_bench.sv
module mdioMgmtSlave_bench;
  localparam int CLK_PERIOD = 80;
  localparam logic [15:0] ID_HI = 16'h1C2A;
  localparam logic [15:0] ID_LO = 16'h5B31;
  localparam logic [4:0]  MY_PHY = 5'b10111;

  logic mdc = 1'b0;
  logic rstN = 1'b0;
  logic mdioIn = 1'b1;
  logic mdioOut, mdioOe;
  logic [4:0] strapPhyAddr = MY_PHY;
  logic strapRxClkDelay = 1'b1, strapTxClkDelay = 1'b0, strapLedMode = 1'b1;
  logic advLock = 1'b0, npLock = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] model [32];

  always #(CLK_PERIOD/2) mdc = ~mdc;

  mdioMgmtSlave u_mdioMgmtSlave (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .strapPhyAddr(strapPhyAddr), .strapRxClkDelay(strapRxClkDelay),
    .strapTxClkDelay(strapTxClkDelay), .strapLedMode(strapLedMode),
    .advLock(advLock), .npLock(npLock)
  );

  function automatic logic bRsv(input logic [4:0] a);
    return (a >= 11 && a <= 14) || a == 18 || a == 19 || a >= 21;
  endfunction
  function automatic logic [15:0] bMask(input logic [4:0] a);
    if (a == 0 || a == 4 || a == 9 || a == 16 || a == 20) return 16'hFFFF;
    if (a == 7) return 16'hB7FF;
    return 16'h0000;
  endfunction
  function automatic logic [15:0] bRst(input logic [4:0] a);
    case (a)
      0: return 16'h1140;  1: return 16'h7969;  2: return ID_HI;   3: return ID_LO;
      4: return 16'h05E1;  6: return 16'h0004;  7: return 16'h2001; 9: return 16'h0300;
      15: return 16'h3000; 16: return 16'h4801; 20: return 16'h0804;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 32; i++) model[i] = bRst(5'(i));
  endtask
  task automatic modelWrite(input logic [4:0] a, input logic [15:0] d);
    if (a == 0 && d[15]) modelReset();
    else if (!bRsv(a)) begin
      logic [15:0] m;
      m = bMask(a) & ((a == 0) ? 16'h7DFF : 16'hFFFF);
      model[a] = (model[a] & ~bMask(a)) | (d & m);
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putBit(input logic b, output logic o, output logic e);
    @(negedge mdc);
    mdioIn = b;
    o = mdioOut;
    e = mdioOe;
  endtask

  task automatic doFrame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input int pre,
                         output logic [15:0] rd, output logic taOk, output logic oeAny);
    logic o, e, oe12, oe13, out13;
    logic [11:0] hdr;
    hdr = {op, phy, ra};
    oeAny = 1'b0;
    rd = '0;
    for (int i = 0; i < pre; i++) begin putBit(1'b1, o, e); oeAny |= e; end
    putBit(1'b0, o, e); oeAny |= e;
    putBit(1'b1, o, e); oeAny |= e;
    for (int i = 11; i >= 0; i--) begin putBit(hdr[i], o, e); oeAny |= e; end
    putBit(1'b1, o, oe12); oeAny |= oe12;
    putBit((op == 2'b01) ? 1'b0 : 1'b1, out13, oe13); oeAny |= oe13;
    for (int i = 15; i >= 0; i--) begin
      putBit((op == 2'b01) ? wd[i] : 1'b1, o, e);
      rd[i] = o;
      oeAny |= e;
    end
    putBit(1'b1, o, e);
    taOk = !oe12 && oe13 && !out13 && !e;
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] rd; logic t, oa;
    doFrame(2'b01, MY_PHY, a, d, 32, rd, t, oa);
  endtask
  task automatic rdReg(input logic [4:0] a, output logic [15:0] d, output logic t);
    logic oa;
    doFrame(2'b10, MY_PHY, a, 16'h0, 32, d, t, oa);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic t, oa;
    void'($urandom(32'd4242));
    repeat (4) @(negedge mdc);
    rstN = 1'b1;
    @(negedge mdc);
    strapPhyAddr = 5'b00100; strapRxClkDelay = 1'b0; strapTxClkDelay = 1'b1; strapLedMode = 1'b0;
    modelReset();

    // R5 reset values, straps captured during reset
    rdReg(5'd0, rd, t);  chk("R5 reg0 reset", rd, 16'h1140);
    rdReg(5'd7, rd, t);  chk("R5 reg7 reset", rd, 16'h2001);
    rdReg(5'd16, rd, t); chk("R5 reg16 strap defaults", rd, 16'h4801);
    rdReg(5'd3, rd, t);  chk("R5 reg3 id", rd, ID_LO);
    rdReg(5'd20, rd, t); chk("R5 reg20 reset", rd, 16'h0804);
    // R3 turnaround timing and data order
    rdReg(5'd2, rd, t);  chk("R3 read data", rd, ID_HI);
    chk("R3 turnaround and release", 16'(t), 16'd1);

    // R4 writable, read-only and partial masks
    wrReg(5'd4, 16'hABCD); rdReg(5'd4, rd, t); chk("R4 reg4 write", rd, 16'hABCD);
    wrReg(5'd1, 16'h0000); rdReg(5'd1, rd, t); chk("R4 reg1 read-only", rd, 16'h7969);
    wrReg(5'd7, 16'hFFFF); rdReg(5'd7, rd, t); chk("R4 reg7 mask", rd, 16'hB7FF);

    // R2 foreign address: the new pin value must not match
    doFrame(2'b01, 5'b00100, 5'd9, 16'h1111, 32, rd, t, oa);
    rdReg(5'd9, rd, t); chk("R2 foreign write ignored", rd, 16'h0300);
    doFrame(2'b10, 5'b00100, 5'd9, 16'h0, 32, rd, t, oa);
    chk("R2 foreign read no drive", 16'(oa), 16'd0);

    // R9 illegal opcodes
    doFrame(2'b00, MY_PHY, 5'd9, 16'h2222, 32, rd, t, oa);
    chk("R9 op00 no drive", 16'(oa), 16'd0);
    doFrame(2'b11, MY_PHY, 5'd9, 16'h3333, 32, rd, t, oa);
    chk("R9 op11 no drive", 16'(oa), 16'd0);
    rdReg(5'd9, rd, t); chk("R9 reg9 unchanged", rd, 16'h0300);

    // R8 reserved addresses
    wrReg(5'd12, 16'hFFFF); rdReg(5'd12, rd, t); chk("R8 reserved write", rd, 16'h0000);
    rdReg(5'd25, rd, t); chk("R8 reserved read", rd, 16'h0000);

    // R7 locks
    advLock = 1'b1;
    wrReg(5'd4, 16'h0001); rdReg(5'd4, rd, t); chk("R7 reg4 locked", rd, 16'hABCD);
    wrReg(5'd9, 16'h0F00); rdReg(5'd9, rd, t); chk("R7 reg9 locked", rd, 16'h0300);
    wrReg(5'd20, 16'h0055); rdReg(5'd20, rd, t); chk("R7 reg20 unaffected", rd, 16'h0055);
    advLock = 1'b0; npLock = 1'b1;
    wrReg(5'd7, 16'h0003); rdReg(5'd7, rd, t); chk("R7 reg7 locked", rd, 16'hB7FF);
    wrReg(5'd4, 16'h0001); rdReg(5'd4, rd, t); chk("R7 reg4 after release", rd, 16'h0001);
    npLock = 1'b0;

    // R1 preamble one short
    begin
      logic o, e;
      putBit(1'b0, o, e);
    end
    doFrame(2'b01, MY_PHY, 5'd4, 16'h1234, 31, rd, t, oa);
    rdReg(5'd4, rd, t); chk("R1 short preamble ignored", rd, 16'h0001);

    // R6 software reset and self-clearing bits
    wrReg(5'd16, 16'h0000);
    wrReg(5'd0, 16'h1200); rdReg(5'd0, rd, t); chk("R6 bit9 self clears", rd, 16'h1000);
    wrReg(5'd0, 16'h8000); rdReg(5'd0, rd, t); chk("R6 reg0 after reset", rd, 16'h1140);
    rdReg(5'd4, rd, t);  chk("R6 reg4 restored", rd, 16'h05E1);
    rdReg(5'd16, rd, t); chk("R6 reg16 latched straps", rd, 16'h4801);
    rdReg(5'd20, rd, t); chk("R6 reg20 restored", rd, 16'h0804);
    modelReset();

    // random traffic against the model (R4, R3, R2)
    for (int n = 0; n < 80; n++) begin
      logic [4:0] a;
      logic [15:0] d;
      int kind;
      a = 5'($urandom % 32);
      d = 16'($urandom);
      kind = $urandom % 4;
      if (kind == 0) begin
        doFrame(2'b10, MY_PHY ^ 5'(1 + $urandom % 31), a, 16'h0, 32, rd, t, oa);
        chk("R2 random foreign read", 16'(oa), 16'd0);
      end else if (kind == 1) begin
        wrReg(a, d);
        modelWrite(a, d);
      end else begin
        rdReg(a, rd, t);
        chk("R4 random read", rd, model[a]);
        chk("R3 random turnaround", 16'(t), 16'd1);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule